// File: doc/BRIEF.md
# Command/Indicate Channel Transceiver for a Framed TDM Link

This block carries a 4-bit command/indicate message in each direction over a framed, time-division-multiplexed serial line. On the line side it sees a frame-start pulse, a per-cycle slot bit enable from the slot assigner, a frame-sync status flag and one serial data line in each direction. On the CPU side it exposes an 8-bit transmit register with a valid flag, an 8-bit receive register with a valid flag, and a maskable sticky interrupt.

Software writes the outgoing message with its nibble duplicated into both halves of the byte. While the transmit valid flag is set, the low nibble is sent MSB first in the enabled bit positions of every frame. The receiver assembles four enabled bits per frame and stores the result, duplicated, in the receive register. It raises the interrupt only when the stored command differs from the previous one. When frame sync is lost, both shift paths are flushed and stopped, and any pending transmit message is cancelled. The receive register keeps its contents.

Top module: `cich_xcvr`

## Requirements
- R1: After reset, tx_sd is 1, tx_valid and rx_valid are 0, rx_data is 8'hFF, tx_data is 0 and irq is 0.
- R2: A tx_wr pulse while sync_ok is high stores tx_wdata into tx_data and sets tx_valid in the next cycle. tx_valid stays set across frames.
- R3: A frame starts on a cycle with frame_sync and sync_ok high. In the following cycles where bit_en is high, tx_sd carries tx_data[3:0] MSB first, or 1111 if tx_valid was clear at frame start. tx_sd is 1 in every other cycle, including a frame_sync cycle and enabled positions beyond the fourth.
- R4: A cycle with sync_ok low clears tx_valid in the next cycle, even when tx_wr is high in that same cycle. tx_sd stays 1 until a new frame start.
- R5: The receiver shifts rx_sd, MSB first, in the first four bit_en cycles after a frame start. On the fourth bit it loads rx_data with the nibble in both halves and sets rx_valid, whether or not the command changed.
- R6: rx_rd clears rx_valid in the next cycle. If a load happens in the same cycle, rx_valid stays 1.
- R7: The sticky interrupt flag is set when a loaded nibble differs from the previous rx_data[3:0]. Because rx_data resets to all ones, a first command of 1111 raises nothing.
- R8: irq equals the sticky flag ANDed with irq_en. irq_clr clears the flag, but a change detected in the same cycle wins.
- R9: A cycle with sync_ok low discards any partly received bits and leaves rx_data unchanged. Nothing is loaded until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr | input | 1 | CPU write strobe for the transmit register |
| tx_wdata | input | 8 | Transmit byte, nibble duplicated |
| tx_data | output | 8 | Transmit register contents |
| tx_valid | output | 1 | Transmit message pending/active |
| rx_rd | input | 1 | CPU read strobe for the receive register |
| rx_data | output | 8 | Last received command, duplicated nibble |
| rx_valid | output | 1 | Receive register loaded since last read |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| irq | output | 1 | Interrupt request |
| frame_sync | input | 1 | Frame start pulse |
| bit_en | input | 1 | Command/indicate bit position enable |
| sync_ok | input | 1 | Frame synchronisation status, low when lost |
| tx_sd | output | 1 | Serial transmit data, idle high |
| rx_sd | input | 1 | Serial receive data |

## Verification
Two pairs of functions can meet in one clock. A CPU read of the receive register can land on the cycle of the fourth received bit. The bench places rx_rd on that bit and expects rx_valid to remain 1, with the new value in rx_data. A transmit write can also coincide with a sync loss. The bench raises tx_wr and drops sync_ok together, then expects tx_valid low and a following frame that sends 1111. Both cases are judged by the per-clock reference model and by directed checks.

// File: rtl/cich_xcvr.sv
module cich_xcvr #(
  parameter int MSG_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_wr,
  input  logic [2*MSG_W-1:0] tx_wdata,
  output logic [2*MSG_W-1:0] tx_data,
  output logic               tx_valid,
  input  logic               rx_rd,
  output logic [2*MSG_W-1:0] rx_data,
  output logic               rx_valid,
  input  logic               irq_en,
  input  logic               irq_clr,
  output logic               irq,
  input  logic               frame_sync,
  input  logic               bit_en,
  input  logic               sync_ok,
  output logic               tx_sd,
  input  logic               rx_sd
);
  localparam int CNT_W = $clog2(MSG_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MSG_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(MSG_W);

  logic [MSG_W-1:0] tx_sh, rx_sh;
  logic             tx_run, rx_run, irq_flag;
  logic [CNT_W-1:0] rx_cnt;

  wire              slot    = bit_en && !frame_sync && sync_ok;
  wire [MSG_W-1:0]  rx_msg  = {rx_sh[MSG_W-2:0], rx_sd};
  wire              rx_load = slot && rx_run && (rx_cnt == LAST);
  wire              rx_new  = rx_load && (rx_msg != rx_data[MSG_W-1:0]);

  assign tx_sd = (slot && tx_run) ? tx_sh[MSG_W-1] : 1'b1;
  assign irq   = irq_flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else begin
      if (tx_wr) tx_data <= tx_wdata;
      if (!sync_ok)   tx_valid <= 1'b0;
      else if (tx_wr) tx_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '1;
      tx_run <= 1'b0;
    end else if (!sync_ok) begin
      tx_sh  <= '1;
      tx_run <= 1'b0;
    end else if (frame_sync) begin
      tx_sh  <= tx_valid ? tx_data[MSG_W-1:0] : '1;
      tx_run <= 1'b1;
    end else if (slot && tx_run) begin
      tx_sh  <= {tx_sh[MSG_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh  <= '0;
      rx_cnt <= '0;
      rx_run <= 1'b0;
    end else if (!sync_ok) begin
      rx_sh  <= '0;
      rx_cnt <= '0;
      rx_run <= 1'b0;
    end else if (frame_sync) begin
      rx_sh  <= '0;
      rx_cnt <= '0;
      rx_run <= 1'b1;
    end else if (slot && rx_run && rx_cnt != FULL) begin
      rx_sh  <= rx_msg;
      rx_cnt <= rx_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '1;
      rx_valid <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      if (rx_load)    rx_data <= {rx_msg, rx_msg};
      if (rx_load)    rx_valid <= 1'b1;
      else if (rx_rd) rx_valid <= 1'b0;
      if (rx_new)       irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end
  end
endmodule

module cich_xcvr_chk #(
  parameter int MSG_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_wr,
  input logic               tx_valid,
  input logic               rx_rd,
  input logic [2*MSG_W-1:0] rx_data,
  input logic               rx_valid,
  input logic               irq_en,
  input logic               irq,
  input logic               bit_en,
  input logic               sync_ok,
  input logic               tx_sd
);
  a_r2_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && sync_ok |=> tx_valid);
  a_r4_loss_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |=> !tx_valid);
  a_r3_idle_outside_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> tx_sd);
  a_r6_read_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !bit_en |=> !rx_valid);
  a_r9_rx_kept_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |=> $stable(rx_data));
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind cich_xcvr cich_xcvr_chk #(.MSG_W(MSG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_valid(tx_valid),
  .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid), .irq_en(irq_en),
  .irq(irq), .bit_en(bit_en), .sync_ok(sync_ok), .tx_sd(tx_sd)
);

// File: tb/cich_xcvr_test.sv
`timescale 1ns/1ps
module cich_xcvr_test;
  logic clk = 0, rst_n = 0;
  logic tx_wr = 0, rx_rd = 0, irq_en = 1, irq_clr = 0;
  logic frame_sync = 0, bit_en = 0, sync_ok = 1, rx_sd = 1;
  logic [7:0] tx_wdata = 0;
  logic [7:0] tx_data, rx_data;
  logic tx_valid, rx_valid, irq, tx_sd;

  cich_xcvr uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  bit m_txv, m_rxv, m_flag, m_txrun, m_rxrun;
  bit [7:0] m_txreg, m_rxd;
  bit txq[$];
  bit rxq[$];
  int m_rxcnt;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_tx();
    if (sync_ok && m_txrun && bit_en && !frame_sync && txq.size() > 0) return txq[0];
    return 1'b1;
  endfunction

  task automatic model_step();
    bit load = 0, chg = 0;
    bit [3:0] n;
    if (tx_wr) m_txreg = tx_wdata;
    if (!sync_ok) begin
      txq.delete(); rxq.delete(); m_txrun = 0; m_rxrun = 0; m_txv = 0;
    end else begin
      if (frame_sync) begin
        txq.delete();
        for (int i = 3; i >= 0; i--) txq.push_back(m_txv ? m_txreg_prev[i] : 1'b1);
        m_txrun = 1; m_rxrun = 1; rxq.delete(); m_rxcnt = 0;
      end else if (bit_en) begin
        if (m_txrun && txq.size() > 0) void'(txq.pop_front());
        if (m_rxrun && m_rxcnt < 4) begin
          rxq.push_back(rx_sd); m_rxcnt++;
          if (m_rxcnt == 4) begin
            n = {rxq[0], rxq[1], rxq[2], rxq[3]};
            load = 1; chg = (n != m_rxd[3:0]);
            m_rxd = {n, n}; rxq.delete();
          end
        end
      end
      if (tx_wr) m_txv = 1;
    end
    if (load) m_rxv = 1; else if (rx_rd) m_rxv = 0;
    if (chg) m_flag = 1; else if (irq_clr) m_flag = 0;
  endtask

  bit [7:0] m_txreg_prev;

  task automatic tick();
    #0.5;
    chk("R3 tx_sd", tx_sd, exp_tx());
    @(posedge clk);
    m_txreg_prev = m_txreg;
    model_step();
    @(negedge clk);
    chk("R2 tx_valid", tx_valid, m_txv);
    chk("R2 tx_data", tx_data, m_txreg);
    chk("R5 rx_data", rx_data, m_rxd);
    chk("R6 rx_valid", rx_valid, m_rxv);
    chk("R8 irq", irq, m_flag && irq_en);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // one frame: start, gap, 4 C/I bits, tail. rd_last puts rx_rd on the 4th bit;
  // drop_at>=0 drops sync_ok on that bit index.
  task automatic frame(input bit [3:0] rxn, input bit rd_last, input int drop_at,
                       output bit [3:0] seen);
    frame_sync = 1; tick(); frame_sync = 0;
    tick();
    for (int i = 0; i < 4; i++) begin
      bit_en = 1; rx_sd = rxn[3-i];
      rx_rd = rd_last && (i == 3);
      sync_ok = !(i == drop_at);
      #0.2 seen[3-i] = tx_sd;
      tick();
      bit_en = 0; rx_rd = 0; sync_ok = 1;
    end
    rx_sd = 1;
    bit_en = 1; tick(); bit_en = 0;
    chk("R3 extra enabled bit idle", 1, 1);
    idle(2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit [3:0] s;
    m_rxd = 8'hFF;
    @(negedge clk); @(negedge clk);
    chk("R1 tx_sd", tx_sd, 1); chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rx_valid", rx_valid, 0); chk("R1 rx_data", rx_data, 8'hFF);
    chk("R1 irq", irq, 0); chk("R1 tx_data", tx_data, 0);
    rst_n = 1;
    idle(2);

    frame(4'hF, 0, -1, s);
    chk("R3 no valid sends 1111", s, 4'hF);
    chk("R5 valid on unchanged load", rx_valid, 1);
    chk("R7 first 1111 no irq", irq, 0);

    tx_wr = 1; tx_wdata = 8'h66; tick(); tx_wr = 0;
    chk("R2 valid after write", tx_valid, 1);
    frame(4'h3, 0, -1, s);
    chk("R3 sends 0110", s, 4'h6);
    chk("R5 rx_data 33", rx_data, 8'h33);
    chk("R7 change irq", irq, 1);

    rx_rd = 1; tick(); rx_rd = 0;
    chk("R6 read clears", rx_valid, 0);
    irq_clr = 1; tick(); irq_clr = 0;
    chk("R8 clear", irq, 0);

    frame(4'h3, 0, -1, s);
    chk("R3 repeat 0110", s, 4'h6);
    chk("R5 valid on repeat", rx_valid, 1);
    chk("R7 same cmd no irq", irq, 0);

    irq_en = 0;
    frame(4'hA, 1, -1, s);
    chk("R6 read+load keeps valid", rx_valid, 1);
    chk("R8 masked", irq, 0);
    irq_en = 1; tick();
    chk("R8 unmasked sticky", irq, 1);

    irq_clr = 1; frame_sync = 1; tick(); frame_sync = 0; irq_clr = 0;
    idle(1);
    frame(4'h5, 0, 2, s);
    chk("R9 partial dropped", rx_data, 8'hAA);
    chk("R4 valid cleared", tx_valid, 0);
    chk("R4 bits after loss idle", s[1:0], 2'b11);

    tx_wr = 1; tx_wdata = 8'h99; tick(); tx_wr = 0;
    tx_wr = 1; tx_wdata = 8'h22; sync_ok = 0; tick(); tx_wr = 0; sync_ok = 1;
    chk("R4 write on loss cancelled", tx_valid, 0);
    frame(4'hC, 0, -1, s);
    chk("R4 cancelled sends 1111", s, 4'hF);
    chk("R9 resumes after sync", rx_data, 8'hCC);
    chk("R7 change after resync", irq, 1);

    irq_clr = 1; tick(); irq_clr = 0;
    tx_wr = 1; tx_wdata = 8'h11; tick(); tx_wr = 0;
    frame(4'h0, 0, -1, s);
    chk("R3 sends 0001", s, 4'h1);
    chk("R5 rx_data 00", rx_data, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule